// File: doc/BRIEF.md
# CPU Bus Cycle Classifier

This block sits beside an 8-bit microprocessor and watches its bus. It reads the active-low control strobes and the low address byte, brings them into the system clock domain, and labels every bus cycle with a 3-bit kind. The cycle kinds are opcode fetch, memory read, memory write, I/O read, I/O write, interrupt acknowledge and DRAM refresh. Code 0 means no valid cycle. The kind is decided from pairs of strobes wherever a pair defines it: machine-cycle-one with memory request, machine-cycle-one with I/O request, and refresh with memory request. The read and write lines only decide the plain memory and I/O accesses.

Next to the kind the block gives three decoded selects, a one-clock strobe at the start of each new cycle, and the last I/O port number. It also gives the last refresh row with a running refresh count, and a halt flag. Two sticky flags are kept. One marks a contradictory strobe combination. The other marks a refresh row that did not follow its predecessor by one, modulo 128. Refresh cycles issued while the processor is halted are classified and counted like any other.

Top module: `bus_cycle_classifier`

## Requirements
- R1: All strobe pins are active low and pass through a two-flop synchroniser. A pin change made before clock edge k shows on `cyc_type`, `cyc_start`, the selects, `io_port`, `halted` and `err_flag` after edge k+2 (the third edge), and not before. It shows on `rfsh_row`, `rfsh_count` and `seq_mismatch` one edge later. Under synchronous active-high reset every output is 0.
- R2: Cycle kinds made by strobe pairs: M1 with MREQ gives 1 (opcode fetch), M1 with IORQ gives 6 (interrupt acknowledge), and RFSH with MREQ gives 7 (refresh).
- R3: Plain accesses: MREQ with RD gives 2, MREQ with WR gives 3, IORQ with RD gives 4, and IORQ with WR gives 5. MREQ or IORQ alone, with no RD or WR and no pair partner, gives 0 with no error. No request strobe also gives 0.
- R4: `cyc_start` is high for exactly one clock when the kind changes to a value other than 0. A kind that is held, or that returns to 0, gives no pulse.
- R5: `mem_sel` is high for kinds 1, 2 and 3. `io_sel` is high for kinds 4 and 5. `rfsh_sel` is high for kind 7. At most one select is high at a time.
- R6: `io_port` takes address bits 7:0 during an I/O read or an I/O write. It holds its value through every other kind, interrupt acknowledge included.
- R7: At the start of each refresh cycle, `rfsh_row` takes address bits 6:0 and `rfsh_count` rises by one. A refresh held over several clocks counts once.
- R8: `seq_mismatch` goes high, and stays high until reset, when a refresh row differs from the previous refresh row plus one, modulo 128. The first refresh after reset is not checked, and the step from 127 to 0 is legal.
- R9: Contradictory combinations give kind 0 and set `err_flag`, which only reset clears. These combinations are: RD with WR; MREQ with IORQ; RFSH with MREQ together with M1, RD or WR; M1 with MREQ and WR; and M1 with IORQ together with RD or WR.
- R10: `halted` follows the HALT pin with the R1 latency. HALT does not change classification, so refresh cycles during halt are classified and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| m1_n | input | 1 | Machine cycle one strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| halt_n | input | 1 | Halt status, active low |
| addr | input | 16 | Processor address bus |
| cyc_type | output | 3 | Registered cycle kind code |
| cyc_start | output | 1 | One-clock pulse at a new non-idle cycle |
| mem_sel | output | 1 | Memory cycle select |
| io_sel | output | 1 | I/O port cycle select |
| rfsh_sel | output | 1 | Refresh cycle select |
| io_port | output | 8 | Last I/O port number |
| rfsh_row | output | 7 | Last refresh row address |
| rfsh_count | output | 16 | Number of refresh cycles since reset |
| halted | output | 1 | Processor is halted |
| err_flag | output | 1 | Sticky contradictory-strobe flag |
| seq_mismatch | output | 1 | Sticky refresh-sequence break flag |

## Verification
The bench goes straight from a fetch to a refresh with no idle gap. A design that only pulsed after idle would miss that start, and one that counted a held refresh twice would drift its count. It walks the refresh row through the wrap from 127 to 0 while halted, which catches a mismatch check done without the 7-bit wrap and a halt that suppresses counting. It then breaks the sequence, and checks that the first refresh after reset is exempt. Random strobe mixes hit every contradictory pair and confirm that the port number survives interrupt acknowledge and memory cycles, and that an error reports idle and stays latched.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_FETCH   = 3'd1,
        CYC_MEM_RD  = 3'd2,
        CYC_MEM_WR  = 3'd3,
        CYC_IO_RD   = 3'd4,
        CYC_IO_WR   = 3'd5,
        CYC_INTACK  = 3'd6,
        CYC_REFRESH = 3'd7
    } cyc_e;

    // Strobes after polarity conversion: 1 means asserted.
    typedef struct packed {
        logic m1;
        logic mreq;
        logic iorq;
        logic rd;
        logic wr;
        logic rfsh;
        logic halt;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    typedef struct packed {
        cyc_e kind;
        logic bad;
    } verdict_t;

    function automatic verdict_t classify(strobe_t s);
        verdict_t v;
        v.kind = CYC_IDLE;
        v.bad  = 1'b0;
        if (s.rd && s.wr) begin
            v.bad = 1'b1;
        end else if (s.mreq && s.iorq) begin
            v.bad = 1'b1;
        end else if (s.mreq) begin
            if (s.rfsh) begin
                if (s.m1 || s.rd || s.wr) v.bad  = 1'b1;
                else                      v.kind = CYC_REFRESH;
            end else if (s.m1) begin
                if (s.wr) v.bad  = 1'b1;
                else      v.kind = CYC_FETCH;
            end else if (s.rd) begin
                v.kind = CYC_MEM_RD;
            end else if (s.wr) begin
                v.kind = CYC_MEM_WR;
            end
        end else if (s.iorq) begin
            if (s.m1) begin
                if (s.rd || s.wr) v.bad  = 1'b1;
                else              v.kind = CYC_INTACK;
            end else if (s.rd) begin
                v.kind = CYC_IO_RD;
            end else if (s.wr) begin
                v.kind = CYC_IO_WR;
            end
        end
        return v;
    endfunction

    function automatic logic kind_is_mem(cyc_e k);
        return (k == CYC_FETCH) || (k == CYC_MEM_RD) || (k == CYC_MEM_WR);
    endfunction

    function automatic logic kind_is_port(cyc_e k);
        return (k == CYC_IO_RD) || (k == CYC_IO_WR);
    endfunction

endpackage

// File: rtl/bcc_sync.sv
module bcc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/bcc_decode.sv
module bcc_decode
    import bcc_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int ROW_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           strb_i,
    input  logic [PORT_W-1:0] addr_i,
    output cyc_e              kind_o,
    output logic              start_o,
    output logic              mem_sel_o,
    output logic              io_sel_o,
    output logic              rfsh_sel_o,
    output logic              err_o,
    output logic              halted_o,
    output logic [PORT_W-1:0] port_o,
    output logic [ROW_W-1:0]  row_addr_o
);

    verdict_t          verd;
    cyc_e              kind_q;
    logic              start_q, mem_q, io_q, rf_q, err_q, halt_q;
    logic [PORT_W-1:0] port_q;
    logic [ROW_W-1:0]  row_q;

    always_comb verd = classify(strb_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= CYC_IDLE;
            start_q <= 1'b0;
            mem_q   <= 1'b0;
            io_q    <= 1'b0;
            rf_q    <= 1'b0;
            err_q   <= 1'b0;
            halt_q  <= 1'b0;
            port_q  <= '0;
            row_q   <= '0;
        end else begin
            kind_q  <= verd.kind;
            start_q <= (verd.kind != CYC_IDLE) && (verd.kind != kind_q);
            mem_q   <= kind_is_mem(verd.kind);
            io_q    <= kind_is_port(verd.kind);
            rf_q    <= (verd.kind == CYC_REFRESH);
            halt_q  <= strb_i.halt;
            row_q   <= addr_i[ROW_W-1:0];
            if (verd.bad) err_q <= 1'b1;
            if (kind_is_port(verd.kind)) port_q <= addr_i;
        end
    end

    assign kind_o     = kind_q;
    assign start_o    = start_q;
    assign mem_sel_o  = mem_q;
    assign io_sel_o   = io_q;
    assign rfsh_sel_o = rf_q;
    assign err_o      = err_q;
    assign halted_o   = halt_q;
    assign port_o     = port_q;
    assign row_addr_o = row_q;

    a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_q, io_q, rf_q}));
    a_r5_mem_kind: assert property (@(posedge clk) disable iff (rst)
        mem_q |-> (kind_q == CYC_FETCH || kind_q == CYC_MEM_RD || kind_q == CYC_MEM_WR));
    a_r4_start_nonidle: assert property (@(posedge clk) disable iff (rst)
        start_q |-> kind_q != CYC_IDLE);
    a_r4_start_changed: assert property (@(posedge clk) disable iff (rst)
        start_q |-> kind_q != $past(kind_q));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r9_bad_is_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> kind_q == CYC_IDLE);
    a_r6_port_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_q) |-> (kind_q == CYC_IO_RD || kind_q == CYC_IO_WR));

endmodule

// File: rtl/bcc_refresh.sv
module bcc_refresh
    import bcc_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cyc_e             kind_i,
    input  logic             start_i,
    input  logic [ROW_W-1:0] row_addr_i,
    output logic [ROW_W-1:0] row_o,
    output logic [CNT_W-1:0] count_o,
    output logic             mismatch_o
);

    localparam logic [ROW_W-1:0] ROW_STEP = ROW_W'(1);
    localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

    logic             hit;
    logic [ROW_W-1:0] row_q, row_next_exp;
    logic [CNT_W-1:0] cnt_q;
    logic             have_q, mism_q;

    assign hit          = start_i && (kind_i == CYC_REFRESH);
    assign row_next_exp = row_q + ROW_STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            cnt_q  <= '0;
            have_q <= 1'b0;
            mism_q <= 1'b0;
        end else if (hit) begin
            row_q  <= row_addr_i;
            cnt_q  <= cnt_q + CNT_STEP;
            have_q <= 1'b1;
            if (have_q && (row_addr_i != row_next_exp)) mism_q <= 1'b1;
        end
    end

    assign row_o      = row_q;
    assign count_o    = cnt_q;
    assign mismatch_o = mism_q;

    a_r8_mismatch_sticky: assert property (@(posedge clk) disable iff (rst)
        mism_q |=> mism_q);
    a_r8_first_exempt: assert property (@(posedge clk) disable iff (rst)
        $rose(mism_q) |-> $past(have_q));
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> cnt_q == $past(cnt_q) + CNT_STEP);
    a_r7_row_on_refresh: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_q) |-> $past(start_i && kind_i == CYC_REFRESH));

endmodule

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier
    import bcc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PORT_W      = 8,
    parameter int ROW_W       = 7,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m1_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rfsh_n,
    input  logic              halt_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        cyc_type,
    output logic              cyc_start,
    output logic              mem_sel,
    output logic              io_sel,
    output logic              rfsh_sel,
    output logic [PORT_W-1:0] io_port,
    output logic [ROW_W-1:0]  rfsh_row,
    output logic [CNT_W-1:0]  rfsh_count,
    output logic              halted,
    output logic              err_flag,
    output logic              seq_mismatch
);

    strobe_t           strb_raw, strb_s;
    logic [PORT_W-1:0] addr_s;
    logic              unused_addr_hi;
    cyc_e              kind;
    logic              start;
    logic [ROW_W-1:0]  row_addr;

    assign unused_addr_hi = ^addr[ADDR_W-1:PORT_W];

    always_comb begin
        strb_raw.m1   = ~m1_n;
        strb_raw.mreq = ~mreq_n;
        strb_raw.iorq = ~iorq_n;
        strb_raw.rd   = ~rd_n;
        strb_raw.wr   = ~wr_n;
        strb_raw.rfsh = ~rfsh_n;
        strb_raw.halt = ~halt_n;
    end

    bcc_sync #(.WIDTH(STROBE_W), .STAGES(SYNC_STAGES)) u_sync_strb (
        .clk (clk),
        .rst (rst),
        .d   (strb_raw),
        .q   (strb_s)
    );

    bcc_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync_addr (
        .clk (clk),
        .rst (rst),
        .d   (addr[PORT_W-1:0]),
        .q   (addr_s)
    );

    bcc_decode #(.PORT_W(PORT_W), .ROW_W(ROW_W)) u_decode (
        .clk        (clk),
        .rst        (rst),
        .strb_i     (strb_s),
        .addr_i     (addr_s),
        .kind_o     (kind),
        .start_o    (start),
        .mem_sel_o  (mem_sel),
        .io_sel_o   (io_sel),
        .rfsh_sel_o (rfsh_sel),
        .err_o      (err_flag),
        .halted_o   (halted),
        .port_o     (io_port),
        .row_addr_o (row_addr)
    );

    bcc_refresh #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_refresh (
        .clk        (clk),
        .rst        (rst),
        .kind_i     (kind),
        .start_i    (start),
        .row_addr_i (row_addr),
        .row_o      (rfsh_row),
        .count_o    (rfsh_count),
        .mismatch_o (seq_mismatch)
    );

    assign cyc_type  = kind;
    assign cyc_start = start;

endmodule

// File: tb/tb_bus_cycle_classifier.sv
module tb_bus_cycle_classifier;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1;
    logic wr_n = 1'b1, rfsh_n = 1'b1, halt_n = 1'b1;
    logic [15:0] addr = 16'h0;

    logic [2:0]  cyc_type;
    logic        cyc_start, mem_sel, io_sel, rfsh_sel, halted, err_flag, seq_mismatch;
    logic [7:0]  io_port;
    logic [6:0]  rfsh_row;
    logic [15:0] rfsh_count;

    bus_cycle_classifier dut (
        .clk(clk), .rst(rst), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .rfsh_n(rfsh_n), .halt_n(halt_n), .addr(addr),
        .cyc_type(cyc_type), .cyc_start(cyc_start), .mem_sel(mem_sel), .io_sel(io_sel),
        .rfsh_sel(rfsh_sel), .io_port(io_port), .rfsh_row(rfsh_row),
        .rfsh_count(rfsh_count), .halted(halted), .err_flag(err_flag),
        .seq_mismatch(seq_mismatch)
    );

    localparam logic [6:0] B_M1 = 7'h40, B_MREQ = 7'h20, B_IORQ = 7'h10, B_RD = 7'h08;
    localparam logic [6:0] B_WR = 7'h04, B_RFSH = 7'h02, B_HALT = 7'h01;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    logic [2:0]  m_last;
    logic [7:0]  m_port;
    logic [6:0]  m_row;
    logic [15:0] m_cnt;
    logic        m_have, m_mism, m_err;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] b, input logic [15:0] a);
        m1_n   = ~b[6];
        mreq_n = ~b[5];
        iorq_n = ~b[4];
        rd_n   = ~b[3];
        wr_n   = ~b[2];
        rfsh_n = ~b[1];
        halt_n = ~b[0];
        addr   = a;
    endtask

    // returns {bad, kind}
    function automatic logic [3:0] ref_kind(input logic [6:0] b);
        logic m1, mq, iq, rd, wr, rf;
        {m1, mq, iq, rd, wr, rf} = b[6:1];
        if (rd && wr)          return 4'b1_000;
        if (mq && iq)          return 4'b1_000;
        if (mq && rf)          return (m1 || rd || wr) ? 4'b1_000 : 4'b0_111;
        if (mq && m1)          return wr ? 4'b1_000 : 4'b0_001;
        if (mq)                return rd ? 4'b0_010 : (wr ? 4'b0_011 : 4'b0_000);
        if (iq && m1)          return (rd || wr) ? 4'b1_000 : 4'b0_110;
        if (iq)                return rd ? 4'b0_100 : (wr ? 4'b0_101 : 4'b0_000);
        return 4'b0_000;
    endfunction

    function automatic logic [2:0] ref_sel(input logic [2:0] t);
        case (t)
            3'd1, 3'd2, 3'd3: return 3'b100;
            3'd4, 3'd5:       return 3'b010;
            3'd7:             return 3'b001;
            default:          return 3'b000;
        endcase
    endfunction

    task automatic check_reset_state;
        chk("R1", "reset cyc_type", cyc_type, 0);
        chk("R1", "reset cyc_start", cyc_start, 0);
        chk("R1", "reset selects", {mem_sel, io_sel, rfsh_sel}, 0);
        chk("R1", "reset io_port", io_port, 0);
        chk("R1", "reset rfsh_row", rfsh_row, 0);
        chk("R1", "reset rfsh_count", rfsh_count, 0);
        chk("R1", "reset halted", halted, 0);
        chk("R9", "err_flag cleared by reset", err_flag, 0);
        chk("R8", "seq_mismatch cleared by reset", seq_mismatch, 0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        drive(7'h0, 16'h0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_last = 0; m_port = 0; m_row = 0; m_cnt = 0;
        m_have = 0; m_mism = 0; m_err = 0;
        @(negedge clk);
        check_reset_state();
    endtask

    task automatic step(input logic [6:0] b, input logic [15:0] a, input bit idle_first, input string tag);
        logic [3:0] v;
        logic [2:0] prev;
        logic       exp_start;
        int         starts;
        if (idle_first) begin
            drive(b & B_HALT, 16'h0);
            repeat (5) @(negedge clk);
            m_last = 3'd0;
        end
        v    = ref_kind(b);
        prev = m_last;
        drive(b, a);
        starts = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (cyc_start) starts++;
            if (i == 2) chk("R1", "kind unchanged before third edge", cyc_type, prev);
            if (i == 3) chk("R1", "kind at third edge", cyc_type, v[2:0]);
        end
        exp_start = (v[2:0] != 3'd0) && (v[2:0] != prev);
        if (v[3]) m_err = 1'b1;
        if (v[2:0] == 3'd4 || v[2:0] == 3'd5) m_port = a[7:0];
        if (v[2:0] == 3'd7 && exp_start) begin
            if (m_have && (a[6:0] != m_row + 7'd1)) m_mism = 1'b1;
            m_row  = a[6:0];
            m_have = 1'b1;
            m_cnt  = m_cnt + 16'd1;
        end
        m_last = v[2:0];
        chk(tag,  "cyc_type", cyc_type, v[2:0]);
        chk("R4", "cyc_start pulses", starts, exp_start ? 1 : 0);
        chk("R5", "selects", {mem_sel, io_sel, rfsh_sel}, ref_sel(v[2:0]));
        chk("R6", "io_port", io_port, m_port);
        chk("R7", "rfsh_row", rfsh_row, m_row);
        chk("R7", "rfsh_count", rfsh_count, m_cnt);
        chk("R8", "seq_mismatch", seq_mismatch, m_mism);
        chk("R9", "err_flag", err_flag, m_err);
        chk("R10", "halted", halted, b[0]);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_last = 0; m_port = 0; m_row = 0; m_cnt = 0;
        m_have = 0; m_mism = 0; m_err = 0;
        do_reset();

        step(B_M1 | B_MREQ | B_RD, 16'h1234, 1'b1, "R2");
        step(B_RFSH | B_MREQ, 16'h3F00, 1'b0, "R2");          // fetch straight into refresh
        step(B_MREQ | B_RD, 16'h8001, 1'b1, "R3");
        step(B_MREQ | B_WR, 16'h8002, 1'b1, "R3");
        step(B_IORQ | B_RD, 16'hFF5A, 1'b1, "R3");
        step(B_IORQ | B_WR, 16'h00A5, 1'b1, "R3");
        step(B_M1 | B_IORQ, 16'h0033, 1'b1, "R2");            // port must hold A5
        step(B_MREQ | B_RD, 16'h0033, 1'b1, "R6");
        step(B_MREQ, 16'h4444, 1'b1, "R3");
        step(B_IORQ, 16'h0044, 1'b1, "R3");
        step(B_MREQ | B_RD, 16'h0010, 1'b1, "R4");
        step(B_MREQ | B_RD, 16'h0011, 1'b0, "R4");            // held: no new pulse

        for (int r = 1; r < 128; r++)
            step(B_HALT | B_RFSH | B_MREQ, 16'(r), 1'b1, "R10");
        step(B_HALT | B_RFSH | B_MREQ, 16'h0080, 1'b1, "R8"); // wrap 127 -> 0
        step(B_HALT | B_RFSH | B_MREQ, 16'h0005, 1'b1, "R8"); // break

        step(B_MREQ | B_RD | B_WR, 16'h0000, 1'b1, "R9");
        step(B_MREQ | B_IORQ | B_RD, 16'h0000, 1'b1, "R9");
        step(B_M1 | B_MREQ | B_WR, 16'h0000, 1'b1, "R9");
        step(B_M1 | B_IORQ | B_RD, 16'h0000, 1'b1, "R9");
        step(B_RFSH | B_MREQ | B_M1, 16'h0000, 1'b1, "R9");
        step(B_MREQ | B_RD, 16'h0077, 1'b1, "R9");            // flag stays set

        for (int n = 0; n < 300; n++) begin
            logic [6:0]  b;
            logic [15:0] a;
            bit          gap;
            b   = 7'($urandom);
            a   = 16'($urandom);
            gap = ($urandom % 4) != 0;
            step(b, a, gap, "R2");
        end

        do_reset();
        step(B_RFSH | B_MREQ, 16'h0009, 1'b1, "R8");          // first after reset: exempt
        step(B_RFSH | B_MREQ, 16'h000B, 1'b1, "R8");          // skips one row
        step(B_RFSH | B_MREQ, 16'h000C, 1'b0, "R7");          // held refresh: no count

        done = 1'b1;
        summary();
        $finish;
    end

endmodule